// File: doc/BRIEF.md
# Bunch crossing identification filter

This block takes one digitised calorimeter sample per bunch crossing (25 ns, 40 MHz in the experiment) and decides which crossing the deposited energy belongs to. A five-tap filter with programmable signed coefficients sharpens the slow detector pulse. A peak finder then looks at three consecutive filter outputs and tags the crossing at the maximum. For a tagged crossing, a 1024-entry lookup table turns the filter value into a calibrated 8-bit transverse energy. Every other crossing reports zero energy.

Pulses large enough to clip the digitiser flatten the top of the pulse, so the peak finder cannot place them. These pulses take a separate path. The first of two consecutive full-scale samples marks the leading edge. The tagged crossing sits a programmable number of crossings after that edge, and its energy is forced to full scale. All results come out after a fixed latency, and that latency is programmable. The lookup table is loaded through a simple write port. The pipeline advances only on cycles where the crossing strobe is high.

Top module: `xing_tagger`

## Requirements
- R1: While reset is asserted and after it is released, with all-zero input, `et_out` and `tag_out` are 0.
- R2: The filter value for crossing n is F[n] = clip((sum over k=0..4 of c[k]*s[n-k]) >>> shift_sel). Here s[j] is the unsigned sample of crossing j and c[k] is the signed 4-bit field `coef_in[4k+3:4k]`. Negative results clip to 0 and results above 1023 clip to 1023.
- R3: Crossing k is peak-tagged when F[k-1] < F[k] and F[k] >= F[k+1]. On a flat top, only the first crossing of the plateau is tagged.
- R4: A peak-tagged crossing reports `tag_out`=1 and `et_out` = table[F[k]]. An untagged crossing reports `tag_out`=0 and `et_out`=0.
- R5: A sample equal to 1023 is saturated. If s[j] and s[j+1] are saturated and s[j-1] is not, crossing j+`sat_off` is tagged with `et_out`=255. This tag wins over any peak tag on the same crossing.
- R6: A peak tag on crossing k is suppressed when any of s[k-1], s[k] or s[k+1] is saturated. A saturation tag on crossing k is not suppressed.
- R7: Setting `lut_we` for one clock writes `lut_wdata` to table entry `lut_addr`. Lookups on every later crossing use the new value.
- R8: The result for crossing k is presented after the (k+3+`lat_sel`)-th enabled clock edge, counting the edge that takes s[0] as edge 0.
- R9: While `xing_en` is low, no pipeline state advances and `et_out`/`tag_out` hold their values.
- R10: An isolated saturated sample, not followed by another saturated sample, produces no saturation tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| xing_en | input | 1 | Crossing strobe; when high, the pipeline advances one crossing |
| smp_in | input | 10 | Unsigned sample of the current crossing |
| coef_in | input | 20 | Five signed 4-bit tap coefficients; tap k is in bits 4k+3:4k |
| shift_sel | input | 3 | Arithmetic right shift applied to the filter sum |
| sat_off | input | 2 | Offset from the saturation leading edge to the tagged crossing |
| lat_sel | input | 3 | Extra output latency in crossings |
| lut_we | input | 1 | Table write enable |
| lut_addr | input | 10 | Table write address |
| lut_wdata | input | 8 | Table write data |
| et_out | output | 8 | Energy of the presented crossing, 0 when untagged |
| tag_out | output | 1 | Presented crossing is identified |

## Verification
Each crossing's result is due exactly 3+`lat_sel` enabled edges after the edge that took its own sample. The peak rule also needs the sample of the next crossing, so the last input a result depends on comes 2+`lat_sel` edges before it appears. The bench drives one sample per falling edge. It reads the outputs at the next falling edge and maps each reading back to crossing m-3-`lat_sel`, where m is the index of the enabled edge just taken. It compares that reading with a value computed from the filter, peak and saturation rules over the whole driven sample array. During strobe gaps no edge is counted, and the bench instead checks that the outputs stay frozen. A rewrite of the table is done between two streams, and the rerun stream must show the new value.

// File: rtl/xet_pkg.sv
`timescale 1ns/1ps
package xet_pkg;
  localparam int SAMP_W = 10;
  localparam int ET_W   = 8;
  localparam logic [SAMP_W-1:0] SAMP_MAX = '1;
  localparam logic [ET_W-1:0]   ET_MAX   = '1;
  typedef logic [SAMP_W-1:0] samp_t;
  typedef logic [ET_W-1:0]   et_t;
  typedef struct packed {
    logic tag;
    et_t  et;
  } ident_t;
endpackage

// File: rtl/xet_rst_sync.sv
`timescale 1ns/1ps
module xet_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb sync_d = {sync_q[0], 1'b1};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/xet_fir.sv
`timescale 1ns/1ps
module xet_fir import xet_pkg::*; #(
  parameter int TAPS    = 5,
  parameter int COEF_W  = 4,
  parameter int SHIFT_W = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     en,
  input  samp_t                    smp,
  input  logic [TAPS*COEF_W-1:0]   coef,
  input  logic [SHIFT_W-1:0]       shift,
  output samp_t                    filt_q
);
  localparam int ACC_W = SAMP_W + COEF_W + $clog2(TAPS) + 1;
  localparam logic signed [ACC_W-1:0] CLIP_HI = ACC_W'(2**SAMP_W - 1);

  samp_t tap_q [TAPS];
  samp_t tap_d [TAPS];
  samp_t filt_d;
  logic signed [ACC_W-1:0] acc;
  logic signed [ACC_W-1:0] shifted;

  // delay line of raw samples, tap 0 is the newest
  always_comb begin
    tap_d[0] = smp;
    for (int i = 1; i < TAPS; i++) tap_d[i] = tap_q[i-1];
  end

  generate
    for (genvar g = 0; g < TAPS; g++) begin : g_tap
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  tap_q[g] <= '0;
        else if (en) tap_q[g] <= tap_d[g];
      end
    end
  endgenerate

  // multiply-accumulate, shift, clip to the sample range
  always_comb begin
    acc = '0;
    for (int i = 0; i < TAPS; i++) begin
      acc = acc + ACC_W'($signed({1'b0, tap_q[i]})) *
                  ACC_W'($signed(coef[i*COEF_W +: COEF_W]));
    end
    shifted = acc >>> shift;
    if (shifted < 0)            filt_d = '0;
    else if (shifted > CLIP_HI) filt_d = SAMP_MAX;
    else                        filt_d = SAMP_W'(shifted);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  filt_q <= '0;
    else if (en) filt_q <= filt_d;
  end
endmodule

// File: rtl/xet_sat.sv
`timescale 1ns/1ps
module xet_sat import xet_pkg::*; #(
  parameter int OFF_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  samp_t            smp,
  input  logic [OFF_W-1:0] off,
  output logic             sat_tag,
  output logic             blk
);
  localparam int DEPTH = 2**OFF_W;

  // hist_q[i] = sample of crossing (m-i) was full scale, after edge m
  logic [3:0]       hist_q, hist_d;
  logic [DEPTH-1:0] edge_q, edge_d;
  logic             lead_c;

  always_comb begin
    hist_d = {hist_q[2:0], smp == SAMP_MAX};
    // leading edge of a saturated run at crossing m-1
    lead_c = hist_q[1] & hist_q[0] & ~hist_q[2];
    edge_d = {edge_q[DEPTH-2:0], lead_c};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '0;
      edge_q <= '0;
    end else if (en) begin
      hist_q <= hist_d;
      edge_q <= edge_d;
    end
  end

  // edge_q[i] holds the leading edge flag of crossing m-2-i
  assign sat_tag = edge_q[off];
  assign blk     = |hist_q[3:1];
endmodule

// File: rtl/xet_lut.sv
`timescale 1ns/1ps
module xet_lut import xet_pkg::*; #(
  parameter int ADDR_W = SAMP_W
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  et_t               wdata,
  input  logic [ADDR_W-1:0] raddr,
  output et_t               rdata
);
  localparam int DEPTH = 2**ADDR_W;

  et_t mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem_q[waddr] <= wdata;
  end

  assign rdata = mem_q[raddr];
endmodule

// File: rtl/xing_tagger.sv
`timescale 1ns/1ps
module xing_tagger import xet_pkg::*; #(
  parameter int TAPS    = 5,
  parameter int COEF_W  = 4,
  parameter int SHIFT_W = 3,
  parameter int OFF_W   = 2,
  parameter int LAT_MAX = 8,
  localparam int LAT_W  = $clog2(LAT_MAX)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   xing_en,
  input  logic [SAMP_W-1:0]      smp_in,
  input  logic [TAPS*COEF_W-1:0] coef_in,
  input  logic [SHIFT_W-1:0]     shift_sel,
  input  logic [OFF_W-1:0]       sat_off,
  input  logic [LAT_W-1:0]       lat_sel,
  input  logic                   lut_we,
  input  logic [SAMP_W-1:0]      lut_addr,
  input  logic [ET_W-1:0]        lut_wdata,
  output logic [ET_W-1:0]        et_out,
  output logic                   tag_out
);
  logic   srst_n;
  samp_t  filt_q;
  samp_t  f1_q, f2_q, f1_d, f2_d;
  logic   peak_c, sat_tag, blk;
  et_t    lut_rd;
  ident_t id_d;
  ident_t dl_q [LAT_MAX];
  ident_t dl_d [LAT_MAX];
  ident_t out_sel;
  logic   id_tag;
  et_t    id_et;

  xet_rst_sync u_rst (.clk(clk), .arst_n(rst_n), .srst_n(srst_n));

  xet_fir #(.TAPS(TAPS), .COEF_W(COEF_W), .SHIFT_W(SHIFT_W)) u_fir (
    .clk(clk), .rst_n(srst_n), .en(xing_en), .smp(smp_in),
    .coef(coef_in), .shift(shift_sel), .filt_q(filt_q)
  );

  xet_sat #(.OFF_W(OFF_W)) u_sat (
    .clk(clk), .rst_n(srst_n), .en(xing_en), .smp(smp_in),
    .off(sat_off), .sat_tag(sat_tag), .blk(blk)
  );

  xet_lut #(.ADDR_W(SAMP_W)) u_lut (
    .clk(clk), .we(lut_we), .waddr(lut_addr), .wdata(lut_wdata),
    .raddr(f1_q), .rdata(lut_rd)
  );

  // filter history: filt_q = F[m-1], f1_q = F[m-2], f2_q = F[m-3]
  always_comb begin
    f1_d = filt_q;
    f2_d = f1_q;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      f1_q <= '0;
      f2_q <= '0;
    end else if (xing_en) begin
      f1_q <= f1_d;
      f2_q <= f2_d;
    end
  end

  // decision for crossing m-2: saturation first, then unblocked peak
  always_comb begin
    peak_c = (f2_q < f1_q) && (f1_q >= filt_q);
    if (sat_tag)           id_d = '{tag: 1'b1, et: ET_MAX};
    else if (peak_c && !blk) id_d = '{tag: 1'b1, et: lut_rd};
    else                   id_d = '0;
  end

  // programmable latency line, stage 0 is the decision register
  always_comb begin
    dl_d[0] = id_d;
    for (int i = 1; i < LAT_MAX; i++) dl_d[i] = dl_q[i-1];
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      for (int i = 0; i < LAT_MAX; i++) dl_q[i] <= '0;
    end else if (xing_en) begin
      dl_q <= dl_d;
    end
  end

  assign out_sel = dl_q[lat_sel];
  assign et_out  = out_sel.et;
  assign tag_out = out_sel.tag;
  assign id_tag  = dl_q[0].tag;
  assign id_et   = dl_q[0].et;
endmodule

// File: rtl/xet_chk.sv
`timescale 1ns/1ps
module xet_chk #(
  parameter int LAT_W = 3,
  parameter int ET_W  = 8
) (
  input logic             clk,
  input logic             srst_n,
  input logic             xing_en,
  input logic [LAT_W-1:0] lat_sel,
  input logic [ET_W-1:0]  et_out,
  input logic             tag_out,
  input logic             peak_c,
  input logic             blk,
  input logic             sat_tag,
  input logic             id_tag,
  input logic [ET_W-1:0]  id_et
);
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!srst_n)
    !xing_en |=> ($stable(et_out) && $stable(tag_out)) || !$stable(lat_sel)); // R9

  AST_SAT_FULL_SCALE: assert property (@(posedge clk) disable iff (!srst_n)
    xing_en && sat_tag |=> id_tag && (id_et == '1)); // R5

  AST_PEAK_TAGGED: assert property (@(posedge clk) disable iff (!srst_n)
    xing_en && peak_c && !blk |=> id_tag); // R3

  AST_BLOCKED_PEAK: assert property (@(posedge clk) disable iff (!srst_n)
    xing_en && blk && !sat_tag |=> !id_tag); // R6

  AST_QUIET_UNTAGGED: assert property (@(posedge clk) disable iff (!srst_n)
    !tag_out |-> et_out == '0); // R4
endmodule

bind xing_tagger xet_chk #(.LAT_W(LAT_W), .ET_W(xet_pkg::ET_W)) u_chk (
  .clk(clk), .srst_n(srst_n), .xing_en(xing_en), .lat_sel(lat_sel),
  .et_out(et_out), .tag_out(tag_out), .peak_c(peak_c), .blk(blk),
  .sat_tag(sat_tag), .id_tag(id_tag), .id_et(id_et)
);

// File: tb/tb_xing_tagger.sv
`timescale 1ns/1ps
module tb_xing_tagger;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        xing_en;
  logic [9:0]  smp_in;
  logic [19:0] coef_in;
  logic [2:0]  shift_sel;
  logic [1:0]  sat_off;
  logic [2:0]  lat_sel;
  logic        lut_we;
  logic [9:0]  lut_addr;
  logic [7:0]  lut_wdata;
  logic [7:0]  et_out;
  logic        tag_out;

  always #10 clk = ~clk;

  xing_tagger dut (
    .clk(clk), .rst_n(rst_n), .xing_en(xing_en), .smp_in(smp_in),
    .coef_in(coef_in), .shift_sel(shift_sel), .sat_off(sat_off),
    .lat_sel(lat_sel), .lut_we(lut_we), .lut_addr(lut_addr),
    .lut_wdata(lut_wdata), .et_out(et_out), .tag_out(tag_out)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  int s_arr [0:127];
  int n_len;
  int coef_v [5];
  int sh_v, off_v, lat_v;
  int lutm [0:1023];

  task automatic check(string req, logic [8:0] act, logic [8:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual tag/et=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int samp(int j);
    if (j < 0 || j >= n_len) return 0;
    return s_arr[j];
  endfunction

  function automatic int filt_m(int j);
    int acc = 0;
    for (int i = 0; i < 5; i++) acc += coef_v[i] * samp(j - i);
    acc = acc >>> sh_v;
    if (acc < 0) acc = 0;
    if (acc > 1023) acc = 1023;
    return acc;
  endfunction

  function automatic bit sat_m(int j);
    return samp(j) == 1023;
  endfunction

  function automatic logic [8:0] exp_val(int k);
    int j = k - off_v;
    bit lead = sat_m(j) && sat_m(j + 1) && !sat_m(j - 1);
    bit peak = (filt_m(k - 1) < filt_m(k)) && (filt_m(k) >= filt_m(k + 1));
    bit blk  = sat_m(k - 1) || sat_m(k) || sat_m(k + 1);
    if (lead) return {1'b1, 8'hFF};
    if (peak && !blk) return {1'b1, 8'(lutm[filt_m(k)])};
    return 9'h0;
  endfunction

  task automatic apply_cfg();
    for (int i = 0; i < 5; i++) coef_in[i*4 +: 4] = 4'(coef_v[i]);
    shift_sel = 3'(sh_v);
    sat_off   = 2'(off_v);
    lat_sel   = 3'(lat_v);
  endtask

  task automatic lut_write(int a, int d);
    @(negedge clk);
    lut_we = 1'b1; lut_addr = 10'(a); lut_wdata = 8'(d);
    lutm[a] = d & 255;
    @(negedge clk);
    lut_we = 1'b0;
  endtask

  task automatic check_k(string req, int k);
    if (k < 0) return;
    check(req, {tag_out, et_out}, exp_val(k));
  endtask

  // one stream: flush, then one sample per enabled edge; result of crossing k
  // is read at the falling edge after enabled edge k+3+lat
  task automatic run_stream(string req, int gap_at);
    int t_len;
    logic [8:0] held;
    apply_cfg();
    xing_en = 1'b1; smp_in = '0;
    repeat (16) @(negedge clk);
    t_len = n_len + lat_v + 8;
    for (int m = 0; m < t_len; m++) begin
      @(negedge clk);
      if (m > 0) check_k(req, m - 1 - 3 - lat_v);
      if (m == gap_at) begin
        xing_en = 1'b0;
        held = {tag_out, et_out};
        for (int g = 0; g < 3; g++) begin
          @(negedge clk);
          check("R9 strobe low holds outputs", {tag_out, et_out}, held);
        end
      end
      smp_in = 10'(samp(m));
      xing_en = 1'b1;
    end
    @(negedge clk);
    check_k(req, t_len - 1 - 3 - lat_v);
  endtask

  task automatic clear_stream(int len);
    n_len = len;
    for (int i = 0; i < 128; i++) s_arr[i] = 0;
  endtask

  task automatic finish_up();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_up();
    end
  end

  initial begin
    void'($urandom(32'd7331));
    rst_n = 1'b0; xing_en = 1'b1; smp_in = 10'd1023;
    lut_we = 1'b0; lut_addr = '0; lut_wdata = '0;
    coef_v = '{1, 0, 0, 0, 0}; sh_v = 0; off_v = 0; lat_v = 0;
    apply_cfg();
    // R1: reset holds outputs at zero even with active input
    repeat (4) @(negedge clk);
    check("R1 during reset", {tag_out, et_out}, 9'h0);
    smp_in = '0;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 after release", {tag_out, et_out}, 9'h0);

    // R7: load the whole table
    for (int a = 0; a < 1024; a++) lut_write(a, (a * 29 + 7) & 255);

    // simple pulse, identity filter
    clear_stream(24);
    s_arr[10] = 100; s_arr[11] = 300; s_arr[12] = 200;
    run_stream("R2 R3 R4 R8 lat0", -1);
    lat_v = 7;
    run_stream("R8 lat7", -1);
    lat_v = 2;
    run_stream("R9 gap in pulse", 14);

    // R3: flat top, only the first crossing of the plateau
    lat_v = 0;
    clear_stream(24);
    s_arr[8] = 50; s_arr[9] = 200; s_arr[10] = 200; s_arr[11] = 50;
    run_stream("R3 flat top", -1);

    // R2: negative taps, shift, clipping high and low
    coef_v = '{7, -3, 0, -1, 2}; sh_v = 1;
    clear_stream(30);
    s_arr[5] = 1000; s_arr[6] = 1000; s_arr[7] = 400;
    s_arr[15] = 10; s_arr[16] = 600; s_arr[17] = 20; s_arr[20] = 5;
    run_stream("R2 clip and shift", -1);

    // R5 R6: saturated run with offset 2
    coef_v = '{1, 2, 1, 0, 0}; sh_v = 2; off_v = 2;
    clear_stream(32);
    s_arr[19] = 600; s_arr[20] = 1023; s_arr[21] = 1023; s_arr[22] = 1023;
    s_arr[23] = 700;
    run_stream("R5 R6 saturated run", -1);
    off_v = 0;
    run_stream("R5 offset 0", -1);

    // R10: isolated saturated sample
    off_v = 1;
    clear_stream(30);
    s_arr[19] = 500; s_arr[20] = 1023; s_arr[21] = 500;
    run_stream("R10 R6 single saturated sample", -1);

    // R7: rewrite the entry used by the simple pulse, then rerun
    coef_v = '{1, 0, 0, 0, 0}; sh_v = 0; off_v = 0; lat_v = 0;
    clear_stream(24);
    s_arr[10] = 100; s_arr[11] = 300; s_arr[12] = 200;
    lut_write(300, 8'h5A);
    run_stream("R7 table rewrite", -1);
    check("R7 rewritten entry expected", exp_val(11), {1'b1, 8'h5A});

    // constrained random streams
    for (int r = 0; r < 30; r++) begin
      for (int i = 0; i < 5; i++) coef_v[i] = int'($urandom_range(15)) - 8;
      sh_v  = int'($urandom_range(7));
      off_v = int'($urandom_range(3));
      lat_v = int'($urandom_range(7));
      clear_stream(48);
      for (int i = 0; i < 48; i++) s_arr[i] = int'($urandom_range(6));
      for (int p = 0; p < 3; p++) begin
        int pos = 4 + int'($urandom_range(36));
        int amp = int'($urandom_range(2000));
        int shp [5];
        shp = '{amp / 5, amp, amp * 2 / 3, amp / 3, amp / 8};
        for (int i = 0; i < 5; i++)
          s_arr[pos + i] = (shp[i] > 1023) ? 1023 : shp[i];
      end
      run_stream("R2 R3 R4 R5 R6 R8 R9 R10 random",
                 (r % 4 == 0) ? 20 : -1);
    end

    done = 1;
    finish_up();
  end
endmodule